// File: doc/BRIEF.md
# Configurable Output Logic Macrocell

This block is a single output cell of a programmable logic device. It takes the sum-of-products term computed for it by the logic array and turns it into a pin value. The pin value is either taken straight from the term or from a one-bit register that captures the term on the rising clock edge, and it is driven true or inverted. A separate per-cell product term decides whether the pin driver is on. When the driver is off, the pin is free to act as an input.

A feedback signal returns to the array. In registered operation it carries the register's own state, which suits state machines. In combinatorial operation it carries the level actually seen on the pin. That level is the cell's own result while the driver is on, and the externally driven level while it is off.

Two terms are shared by every cell. One is an asynchronous reset that clears the register at once. The other is a synchronous preset that sets it on the next edge. The asynchronous reset also serves as the power-up clear.

The register is modelled as a two-state machine:
- States: `ST_CLEAR` (holds 0) and `ST_SET` (holds 1).
- Transitions on a rising clock edge:
  - `ST_CLEAR`→`ST_SET` when the preset or the sum term is 1.
  - `ST_SET`→`ST_CLEAR` when both are 0.
  - Otherwise the state holds.
- Asynchronous reset forces `ST_CLEAR` from either state with no clock.

Top module: `olmc_cell`

## Requirements
- R1: The mode is chosen by `{cfg_comb, cfg_high}`: 00 is registered with active-low output, 01 is registered with active-high output, 10 is combinatorial with active-low output, and 11 is combinatorial with active-high output.
- R2: With reset and preset inactive, the register takes the value of `sum_term` on each rising edge of `clk` and holds it between edges.
- R3: While `arst_term` is 1, the register is 0 at once with no clock edge. In mode 00 this shows as `pin_out`=1 right after reset.
- R4: With `arst_term` at 0, `spre_term`=1 at a rising edge sets the register to 1 whatever `sum_term` is.
- R5: When `arst_term` and `spre_term` are both 1, the register stays 0.
- R6: In registered modes, `fb` equals the register state. It does not depend on the output polarity or on `pin_in`.
- R7: In combinatorial modes, `fb` equals `pin_in`.
- R8: `pin_oe` equals `oe_term` in every mode. `pin_out` still carries the cell result while `pin_oe` is 0.
- R9: In registered modes, polarity is applied after the register: `pin_out` is the state for 01 and the inverted state for 00.
- R10: In combinatorial modes, `pin_out` follows `sum_term` without a clock, true for 11 and inverted for 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock, rising edge |
| arst_term | input | 1 | Shared asynchronous reset term, active high |
| spre_term | input | 1 | Shared synchronous preset term, active high |
| sum_term | input | 1 | This cell's sum-of-products result |
| oe_term | input | 1 | This cell's output-enable product term |
| cfg_comb | input | 1 | 1 selects combinatorial, 0 selects registered |
| cfg_high | input | 1 | 1 selects active-high, 0 selects active-low |
| pin_in | input | 1 | Level currently present on the pin |
| pin_out | output | 1 | Value for the pin driver |
| pin_oe | output | 1 | Pin driver enable |
| fb | output | 1 | Feedback to the logic array |

## Verification
A wrong register state shows at `fb` and, in registered modes, at `pin_out` right after the clock edge that produced it. Reset errors show without any edge. A lost or misplaced polarity inversion shows at `pin_out` alone, while `fb` keeps the true state, so comparing the two separates polarity faults from state faults. In combinatorial modes a wrong feedback source shows only when the driver is off and the external level differs from the cell result, so those cases are driven on purpose.

// File: rtl/olmc_pkg.sv
package olmc_pkg;

    // Mode code is {cfg_comb, cfg_high}
    typedef enum logic [1:0] {
        MODE_REG_LOW   = 2'b00,
        MODE_REG_HIGH  = 2'b01,
        MODE_COMB_LOW  = 2'b10,
        MODE_COMB_HIGH = 2'b11
    } cell_mode_e;

    typedef enum logic {
        ST_CLEAR = 1'b0,
        ST_SET   = 1'b1
    } reg_state_e;

    typedef struct packed {
        logic registered;
        logic active_high;
    } mode_ctl_t;

endpackage

// File: rtl/olmc_mode_decode.sv
module olmc_mode_decode
    import olmc_pkg::*;
(
    input  logic      cfg_comb,
    input  logic      cfg_high,
    output mode_ctl_t ctl
);

    cell_mode_e mode;

    assign mode = cell_mode_e'({cfg_comb, cfg_high});

    always_comb begin
        ctl = '0;
        unique case (mode)
            MODE_REG_LOW:   begin ctl.registered = 1'b1; ctl.active_high = 1'b0; end
            MODE_REG_HIGH:  begin ctl.registered = 1'b1; ctl.active_high = 1'b1; end
            MODE_COMB_LOW:  begin ctl.registered = 1'b0; ctl.active_high = 1'b0; end
            MODE_COMB_HIGH: begin ctl.registered = 1'b0; ctl.active_high = 1'b1; end
            default:        ctl = '0;
        endcase
    end

endmodule

// File: rtl/olmc_state_reg.sv
module olmc_state_reg
    import olmc_pkg::*;
(
    input  logic       clk,
    input  logic       arst_term,
    input  logic       spre_term,
    input  logic       sum_term,
    output reg_state_e state_q
);

    reg_state_e state_d;

    // State register: the asynchronous clear wins over everything
    always_ff @(posedge clk or posedge arst_term) begin
        if (arst_term) begin
            state_q <= ST_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: preset first, then the sampled sum term
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR: begin
                if (spre_term || sum_term) state_d = ST_SET;
            end
            ST_SET: begin
                if (!spre_term && !sum_term) state_d = ST_CLEAR;
            end
            default: state_d = ST_CLEAR;
        endcase
    end

endmodule

// File: rtl/olmc_pin_drive.sv
module olmc_pin_drive
    import olmc_pkg::*;
(
    input  mode_ctl_t  ctl,
    input  reg_state_e state_q,
    input  logic       sum_term,
    input  logic       oe_term,
    input  logic       pin_in,
    output logic       pin_out,
    output logic       pin_oe,
    output logic       fb
);

    logic core_val;

    // Output process: pick the source, then apply polarity
    always_comb begin
        core_val = ctl.registered ? (state_q == ST_SET) : sum_term;
        pin_out  = ctl.active_high ? core_val : ~core_val;
        pin_oe   = oe_term;
        fb       = ctl.registered ? (state_q == ST_SET) : pin_in;
    end

endmodule

// File: rtl/olmc_cell.sv
module olmc_cell
    import olmc_pkg::*;
(
    input  logic clk,
    input  logic arst_term,
    input  logic spre_term,
    input  logic sum_term,
    input  logic oe_term,
    input  logic cfg_comb,
    input  logic cfg_high,
    input  logic pin_in,
    output logic pin_out,
    output logic pin_oe,
    output logic fb
);

    mode_ctl_t  ctl;
    reg_state_e state_q;

    olmc_mode_decode u_dec (
        .cfg_comb (cfg_comb),
        .cfg_high (cfg_high),
        .ctl      (ctl)
    );

    olmc_state_reg u_reg (
        .clk       (clk),
        .arst_term (arst_term),
        .spre_term (spre_term),
        .sum_term  (sum_term),
        .state_q   (state_q)
    );

    olmc_pin_drive u_drv (
        .ctl      (ctl),
        .state_q  (state_q),
        .sum_term (sum_term),
        .oe_term  (oe_term),
        .pin_in   (pin_in),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe),
        .fb       (fb)
    );

endmodule

// File: rtl/olmc_cell_chk.sv
module olmc_cell_chk (
    input logic clk,
    input logic arst_term,
    input logic spre_term,
    input logic sum_term,
    input logic cfg_comb,
    input logic cfg_high,
    input logic pin_in,
    input logic pin_out,
    input logic fb,
    input logic state_bit
);

    // R2: capture of the sum term at an edge
    a_r2_capture: assert property (@(posedge clk) disable iff (arst_term)
        !spre_term |=> state_bit == $past(sum_term));

    // R4: preset sets on the next edge
    a_r4_preset: assert property (@(posedge clk) disable iff (arst_term)
        spre_term |=> state_bit);

    // R3 and R5: reset holds the register clear even with preset active
    a_r5_reset_over_preset: assert property (@(posedge clk)
        arst_term |-> !state_bit);

    // R6: registered feedback carries the state
    a_r6_fb_state: assert property (@(posedge clk) disable iff (arst_term)
        !cfg_comb |-> fb == state_bit);

    // R7: combinatorial feedback carries the pin level
    a_r7_fb_pin: assert property (@(posedge clk) disable iff (arst_term)
        cfg_comb |-> fb == pin_in);

    // R9: registered active-low output is the inverse of the feedback
    a_r9_low_pol: assert property (@(posedge clk) disable iff (arst_term)
        (!cfg_comb && !cfg_high) |-> pin_out != fb);

endmodule

bind olmc_cell olmc_cell_chk u_chk (
    .clk       (clk),
    .arst_term (arst_term),
    .spre_term (spre_term),
    .sum_term  (sum_term),
    .cfg_comb  (cfg_comb),
    .cfg_high  (cfg_high),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .fb        (fb),
    .state_bit (state_q == olmc_pkg::ST_SET)
);

// File: tb/tb_olmc_cell.sv
`timescale 1ns/1ps
module tb_olmc_cell;

    logic clk = 1'b0;
    logic arst_term, spre_term, sum_term, oe_term, cfg_comb, cfg_high;
    logic ext_level;
    logic pin_in, pin_out, pin_oe, fb;
    int   errors = 0;
    int   checks = 0;

    always #5 clk = ~clk;

    // Pad model: driver wins when enabled, otherwise the external level
    assign pin_in = pin_oe ? pin_out : ext_level;

    olmc_cell dut (
        .clk(clk), .arst_term(arst_term), .spre_term(spre_term),
        .sum_term(sum_term), .oe_term(oe_term), .cfg_comb(cfg_comb),
        .cfg_high(cfg_high), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .fb(fb)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic edge_then_sample();
        @(posedge clk);
        #2;
    endtask

    task automatic t_reset();
        // R3: mode 00 after reset shows a high pin, feedback low
        check("R3 pin after reset", pin_out, 1'b1);
        check("R6 fb after reset", fb, 1'b0);
        check("R8 oe follows term", pin_oe, 1'b1);
        @(negedge clk); arst_term = 1'b0;
    endtask

    task automatic t_capture();
        @(negedge clk); cfg_comb = 0; cfg_high = 1; sum_term = 1;
        #1 check("R2 holds before edge", pin_out, 1'b0);
        edge_then_sample();
        check("R2 captured one", pin_out, 1'b1);
        check("R6 fb state one", fb, 1'b1);
        @(negedge clk); sum_term = 0;
        edge_then_sample();
        check("R2 captured zero", pin_out, 1'b0);
    endtask

    task automatic t_preset();
        @(negedge clk); spre_term = 1; sum_term = 0;
        edge_then_sample();
        check("R4 preset sets", pin_out, 1'b1);
        @(negedge clk); spre_term = 0;
        edge_then_sample();
        check("R2 after preset release", fb, 1'b0);
    endtask

    task automatic t_async();
        @(negedge clk); sum_term = 1;
        edge_then_sample();
        check("R2 set before clear", fb, 1'b1);
        @(negedge clk); arst_term = 1;
        #1 check("R3 clear without edge", pin_out, 1'b0);
        @(negedge clk); spre_term = 1;
        edge_then_sample();
        check("R5 reset beats preset", pin_out, 1'b0);
        @(negedge clk); arst_term = 0; spre_term = 0; sum_term = 0;
    endtask

    task automatic t_polarity();
        @(negedge clk); cfg_high = 1; sum_term = 1;
        edge_then_sample();
        @(negedge clk); cfg_high = 0;
        #1 check("R9 low polarity inverts", pin_out, 1'b0);
        check("R6 fb ignores polarity", fb, 1'b1);
        @(negedge clk); oe_term = 0; ext_level = 0;
        #1 check("R6 fb ignores pin", fb, 1'b1);
        check("R8 oe released", pin_oe, 1'b0);
        check("R8 value still driven", pin_out, 1'b0);
        @(negedge clk); oe_term = 1;
    endtask

    task automatic t_comb();
        @(negedge clk); cfg_comb = 1; cfg_high = 1; sum_term = 0;
        #1 check("R10 comb high zero", pin_out, 1'b0);
        sum_term = 1;
        #1 check("R10 comb high no clock", pin_out, 1'b1);
        cfg_high = 0;
        #1 check("R1 mode 10 inverts", pin_out, 1'b0);
        check("R7 fb is pin enabled", fb, 1'b0);
    endtask

    task automatic t_fb_comb();
        @(negedge clk); cfg_high = 1; sum_term = 0; oe_term = 0; ext_level = 1;
        #1 check("R7 fb external one", fb, 1'b1);
        ext_level = 0; sum_term = 1;
        #1 check("R7 fb external zero", fb, 1'b0);
        oe_term = 1;
        #1 check("R7 fb own result", fb, 1'b1);
    endtask

    initial begin
        arst_term = 1; spre_term = 0; sum_term = 0; oe_term = 1;
        cfg_comb = 0; cfg_high = 0; ext_level = 0;
        #12;
        t_reset();
        t_capture();
        t_preset();
        t_async();
        t_polarity();
        t_comb();
        t_fb_comb();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100000;
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule